// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Result Flags

This block is the combinational execute unit of a single-cycle 32-bit integer core. Two operands and a four-bit operation code arrive on plain input pins. In the same cycle the block returns a result word and two flags that branch logic further along the datapath can test. The operations cover wrapping addition and subtraction, three kinds of shift, bitwise logic, and signed and unsigned compare-and-set. Two copy modes forward either operand unchanged. The copy of operand B lets an upper-immediate load write its immediate straight back. The copy of operand A does the same for a program-counter value.

The block holds no state and has no handshake. Its inputs are control and data values that the surrounding single-cycle datapath keeps stable for the whole cycle, so there is no valid/ready pair and back-pressure does not apply. The outputs are valid one combinational delay after the inputs settle. The operand width is a parameter (default 32). The shift amount takes the low log2(width) bits of operand B.

Top module: `alu_core`

## Requirements
- R1: Code 0 outputs A+B and code 1 outputs A-B, both wrapped modulo 2^32 with no overflow indication.
- R2: Code 2 shifts A left by B[4:0], filling with zeros. Bits B[31:5] have no effect.
- R3: Code 3 shifts A right by B[4:0], filling the vacated upper bits with zeros. Bits B[31:5] have no effect.
- R4: Code 4 shifts A right by B[4:0], copying A[31] into the vacated upper bits. Bits B[31:5] have no effect.
- R5: Code 5 outputs A AND B, code 6 outputs A OR B, and code 7 outputs A XOR B.
- R6: Code 8 outputs 1 when A is less than B as two's complement numbers, and 0 otherwise. This holds even when A-B overflows.
- R7: Code 9 outputs 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R8: Code 10 outputs A unchanged and code 11 outputs B unchanged.
- R9: Codes 12 to 15 output zero for any operands.
- R10: zero_flag is 1 exactly when the 32-bit result is zero.
- R11: less_flag equals bit 0 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, with the encoding given in R1 to R9 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, which also supplies the shift amount |
| result | output | 32 | Result of the selected operation |
| zero_flag | output | 1 | High when result is all zeros |
| less_flag | output | 1 | Copy of result bit 0 |

## Verification
The hardest case to reach from the ports is a signed compare whose subtraction overflows. Here the operand signs differ and the sign of the difference gives the wrong answer. Uniform random operands rarely land exactly on the extremes, so the stimulus mixes directed pairs such as the most negative value against small positives with random draws biased toward 0, all-ones, 0x80000000 and 0x7FFFFFFF. Shift vectors deliberately set bits of B above the shift field, so that any use of those bits changes the result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLL   = 4'd2,
    OP_SRL   = 4'd3,
    OP_SRA   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_SLT   = 4'd8,
    OP_SLTU  = 4'd9,
    OP_PASSA = 4'd10,
    OP_PASSB = 4'd11
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic [W:0] b_ext;
  logic [W:0] cin_ext;
  logic [W:0] full;

  assign b_ext   = {1'b0, (sub ? ~b : b)};
  assign cin_ext = {{W{1'b0}}, sub};
  assign full    = {1'b0, a} + b_ext + cin_ext;
  assign sum     = full[W-1:0];

  // When subtracting, a clear carry out means a borrow, so a < b unsigned.
  assign lt_unsigned = ~full[W];
  // When the signs differ, the sign of a decides, which avoids the overflow case.
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : full[W-1];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] shamt,
  input  logic          right,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic          fill;
  logic [W-1:0]  src;
  logic [W-1:0]  stage [SW+1];

  assign fill = right & arith & a[W-1];

  // Left shifts reuse the right-shift stages by reversing the bits on entry and exit.
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign src[i] = right ? a[i] : a[W-1-i];
  end

  assign stage[0] = src;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = shamt[s] ? {{SH{fill}}, stage[s][W-1:SH]} : stage[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign y[i] = right ? stage[SW][i] : stage[SW][W-1-i];
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         zero,
  output logic         less
);
  assign zero = ~|res;
  assign less = res[0];
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             less_flag
);
  import alu_pkg::*;

  localparam int SW = $clog2(WIDTH);

  logic             do_sub;
  logic [WIDTH-1:0] sum;
  logic             lt_s;
  logic             lt_u;
  logic             sh_right;
  logic             sh_arith;
  logic [WIDTH-1:0] sh_out;

  assign do_sub   = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign sh_right = (op_sel != OP_SLL);
  assign sh_arith = (op_sel == OP_SRA);

  alu_addsub #(.W(WIDTH)) u_addsub (
    .a          (opnd_a),
    .b          (opnd_b),
    .sub        (do_sub),
    .sum        (sum),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  alu_shifter #(.W(WIDTH), .SW(SW)) u_shift (
    .a    (opnd_a),
    .shamt(opnd_b[SW-1:0]),
    .right(sh_right),
    .arith(sh_arith),
    .y    (sh_out)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:           result = sum;
      OP_SLL, OP_SRL, OP_SRA:   result = sh_out;
      OP_AND:                   result = opnd_a & opnd_b;
      OP_OR:                    result = opnd_a | opnd_b;
      OP_XOR:                   result = opnd_a ^ opnd_b;
      OP_SLT:                   result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU:                  result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_PASSA:                 result = opnd_a;
      OP_PASSB:                 result = opnd_b;
      default:                  result = '0;
    endcase
  end

  alu_flags #(.W(WIDTH)) u_flags (
    .res (result),
    .zero(zero_flag),
    .less(less_flag)
  );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             less_flag
);
  always_comb begin
    // R10: subtracting equal operands must raise the zero flag, and unequal ones must not
    if (op_sel == 4'd1) assert_sub_zero_R10 : assert (zero_flag == (opnd_a == opnd_b));
    // R11: after a signed compare, less_flag reports the ordering of the operands
    if (op_sel == 4'd8) assert_slt_less_R11 : assert (less_flag == ($signed(opnd_a) < $signed(opnd_b)));
    // R6 / R7: compares produce only 0 or 1
    if (op_sel == 4'd8 || op_sel == 4'd9) assert_cmp_narrow_R6 : assert (result[WIDTH-1:1] == '0);
    // R7: unsigned compare result tracks operand ordering
    if (op_sel == 4'd9) assert_sltu_order_R7 : assert (result[0] == (opnd_a < opnd_b));
    // R8: copy modes leave the operand untouched
    if (op_sel == 4'd10) assert_pass_a_R8 : assert (result == opnd_a);
    if (op_sel == 4'd11) assert_pass_b_R8 : assert (result == opnd_b);
    // R9: unused codes give zero, so zero_flag must be high
    if (op_sel >= 4'd12) assert_unused_zero_R9 : assert (result == '0 && zero_flag);
    // R2: a shift by a multiple of 32 in B leaves A unchanged
    if (op_sel == 4'd2 && opnd_b[4:0] == 5'd0) assert_sll_lowbits_R2 : assert (result == opnd_a);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel   (op_sel),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .zero_flag(zero_flag),
  .less_flag(less_flag)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        zero_flag;
  logic        less_flag;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu_core u0 (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .zero_flag(zero_flag),
    .less_flag(less_flag)
  );

  function automatic logic [31:0] model(input int op, input logic [31:0] a, input logic [31:0] b);
    int sh;
    sh = int'(b % 32);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a << sh;
      3:  return a >> sh;
      4:  return $unsigned($signed(a) >>> sh);
      5:  return a & b;
      6:  return a | b;
      7:  return a ^ b;
      8:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      9:  return (a < b) ? 32'd1 : 32'd0;
      10: return a;
      11: return b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input int op);
    case (op)
      0, 1:    return "R1";
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5, 6, 7: return "R5";
      8:       return "R6";
      9:       return "R7";
      10, 11:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    op_sel = 4'(op);
    opnd_a = a;
    opnd_b = b;
    exp = model(op, a, b);
    @(negedge clk);
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h result got %h exp %h", tag(op), op, a, b, result, exp);
    end
    n_cmp++;
    if (zero_flag !== (exp == 32'd0)) begin
      n_bad++;
      $display("FAIL R10 op=%0d zero_flag got %b exp %b", op, zero_flag, exp == 32'd0);
    end
    n_cmp++;
    if (less_flag !== exp[0]) begin
      n_bad++;
      $display("FAIL R11 op=%0d less_flag got %b exp %b", op, less_flag, exp[0]);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: code 0 with zero operands gives a zero result (R1, R10)
    n_cmp++;
    if (result !== 32'd0 || zero_flag !== 1'b1 || less_flag !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 idle got %h/%b/%b exp 0/1/0", result, zero_flag, less_flag);
    end
    apply(0, 32'hFFFF_FFFF, 32'd1);           // R1 wraps to zero
    apply(1, 32'd0, 32'd1);                   // R1 wraps to all ones
    apply(1, 32'h1234_5678, 32'h1234_5678);   // R10 equal operands
    apply(2, 32'h0000_0001, 32'hFFFF_FFE3);   // R2 upper bits of B ignored
    apply(2, 32'hDEAD_BEEF, 32'h0000_0020);   // R2 amount 0 via masking
    apply(3, 32'h8000_0000, 32'h0000_001F);   // R3 to bit 0, R11
    apply(3, 32'hF000_000F, 32'hABCD_0044);   // R3 upper B ignored
    apply(4, 32'h8000_0000, 32'h0000_001F);   // R4 sign fill
    apply(4, 32'h7000_0000, 32'hFFFF_FFE4);   // R4 positive
    apply(5, 32'hF0F0_F0F0, 32'hFF00_FF00);   // R5
    apply(6, 32'hF0F0_F0F0, 32'h0F0F_0F0F);   // R5
    apply(7, 32'hAAAA_AAAA, 32'hAAAA_AAAA);   // R5 gives zero
    apply(8, 32'hFFFF_FFFF, 32'd1);           // R6 negative < positive
    apply(8, 32'h8000_0000, 32'h0000_0001);   // R6 overflow in the difference
    apply(8, 32'h7FFF_FFFF, 32'h8000_0000);   // R6 overflow, other direction
    apply(8, 32'd5, 32'd5);                   // R6 equal
    apply(9, 32'hFFFF_FFFF, 32'd1);           // R7
    apply(9, 32'd1, 32'hFFFF_FFFF);           // R7
    apply(10, 32'hCAFE_F00D, 32'h1111_1111);  // R8
    apply(11, 32'h1111_1111, 32'h1234_5000);  // R8
    for (int op = 12; op < 16; op++) apply(op, 32'hFFFF_FFFF, 32'h8000_0001); // R9
    for (int k = 0; k < 300; k++) begin
      for (int op = 0; op < 16; op++) apply(op, pick(), pick());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule